// File: doc/BRIEF.md
# Dual-Convention Host Bus Front End

This block connects an external processor bus to an internal word-wide register/RAM port. The host side reuses one pair of control pins for two strobe conventions. In the first, a data strobe is paired with a read/write direction flag. In the second, the same two pins act as separate read and write strobes, and the data carried on the pins is the bitwise complement of the internal value in both directions.

A second configuration input selects between a 16-bit data path and an 8-bit data path. In 8-bit mode the upper-byte select pin picks one byte lane of the addressed internal word. Byte writes update only that lane, through a byte enable on the internal port.

Each host access is turned into one request on the internal port. The request is held until that port accepts it. Only then is the active-low acknowledge driven to the host, and for reads the data pins are driven at the same time. Host strobes pass through a two-flop synchronizer. When the host lets go of its strobe, the acknowledge is withdrawn and the data pins are released within a short fixed number of cycles.

Top module: `hba_top`

## Requirements
- R1: During and directly after reset, `host_ack_n` is 1, `host_data_oe` is 2'b00 and `mem_req` is 0.
- R2: With `cfg_sep_strobe`=0, a low `host_strb_n` starts an access. `host_dir`=0 writes the pin data into the internal word at `host_addr`, and `host_dir`=1 reads that word onto the pins without inversion.
- R3: With `cfg_sep_strobe`=1, a low `host_strb_n` is a read strobe and a low `host_dir` is a write strobe. If both are low, the write takes precedence. Data crossing between the pins and the internal port is inverted in both directions.
- R4: `host_ack_n` falls only on the cycle after the internal port returns `mem_ack` for a pending `mem_req`. `host_data_oe` is nonzero only while `host_ack_n` is 0 and the access is a read.
- R5: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values. `mem_addr` equals `host_addr` in both widths.
- R6: With `cfg_byte_mode`=0, `mem_be` is 2'b11, both lanes are driven on reads (`host_data_oe`=2'b11), and `host_hi_sel` has no effect.
- R7: With `cfg_byte_mode`=1, a write changes only the lane chosen by `host_hi_sel` (0 = bits 7:0, 1 = bits 15:8) and takes its value from pins 7:0. `mem_be` is then 2'b01 or 2'b10, and pins 15:8 are ignored.
- R8: With `cfg_byte_mode`=1, a read drives the chosen lane on pins 7:0 with `host_data_oe`=2'b01. The upper lane stays tri-stated.
- R9: After the host releases its strobe(s), `host_ack_n` returns to 1 and `host_data_oe` to 2'b00 within three clock cycles.
- R10: A strobe that goes active before clock edge k cannot raise `mem_req` before edge k+2, because it first passes through the two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sep_strobe | input | 1 | 0: strobe plus direction; 1: separate read/write strobes with inverted data |
| cfg_byte_mode | input | 1 | 0: 16-bit data path; 1: 8-bit data path with byte select |
| host_addr | input | AW | Host word address |
| host_hi_sel | input | 1 | Upper-byte select, used as byte address LSB in 8-bit mode |
| host_strb_n | input | 1 | Data strobe (mode 0) or read strobe (mode 1), active low |
| host_dir | input | 1 | Direction flag, 0 = write (mode 0), or write strobe, active low (mode 1) |
| host_data_i | input | DW | Data pins as seen from outside |
| host_data_o | output | DW | Data the block drives onto the pins |
| host_data_oe | output | 2 | Per-lane output enable: bit 0 = pins 7:0, bit 1 = pins 15:8 |
| host_ack_n | output | 1 | Active-low acknowledge: 0 = done, 1 = wait |
| mem_req | output | 1 | Internal request valid |
| mem_we | output | 1 | Internal request is a write |
| mem_addr | output | AW | Internal word address |
| mem_wdata | output | DW | Internal write data |
| mem_be | output | 2 | Internal byte enables |
| mem_ack | input | 1 | Internal port accepts the request; read data valid |
| mem_rdata | input | DW | Internal read data, valid with `mem_ack` |

## Verification
The main function is swept over all four combinations of strobe convention and data width, both values of the byte select, eight spread word addresses, and three data patterns whose two bytes always differ. Because the bytes differ, a swapped lane, a missed inversion or a byte write that spills into its neighbour each produce a miscompare. Driving the select high in 16-bit mode and garbage on pins 15:8 in 8-bit mode shows whether those inputs are correctly ignored. The internal port's acceptance latency is varied from zero to three cycles, which separates an acknowledge tied to acceptance from one on a fixed delay. The release time and the earliest request cycle are measured on every access.

// File: rtl/hba_pkg.sv
package hba_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DONE = 2'd2
    } hba_state_e;

    localparam int unsigned HBA_LANES = 2;
endpackage

// File: rtl/hba_sync.sv
module hba_sync #(
    parameter int unsigned W         = 2,
    parameter logic [W-1:0] RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = d_i;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '{s1: RESET_VAL, s2: RESET_VAL};
        end else begin
            sy_q <= sy_d;
        end
    end

    assign q_o = sy_q.s2;
endmodule

// File: rtl/hba_wr_fmt.sv
module hba_wr_fmt #(
    parameter int unsigned DW = 16
) (
    input  logic          sep_i,
    input  logic          byte_i,
    input  logic          hi_i,
    input  logic [DW-1:0] pins_i,
    output logic [DW-1:0] wdata_o,
    output logic [1:0]    be_o
);
    localparam int unsigned HW = DW / 2;

    logic [DW-1:0] val;

    always_comb begin
        val = sep_i ? ~pins_i : pins_i;
        if (byte_i) begin
            wdata_o = {val[HW-1:0], val[HW-1:0]};
            be_o    = hi_i ? 2'b10 : 2'b01;
        end else begin
            wdata_o = val;
            be_o    = 2'b11;
        end
    end
endmodule

// File: rtl/hba_rd_fmt.sv
module hba_rd_fmt #(
    parameter int unsigned DW = 16
) (
    input  logic          sep_i,
    input  logic          byte_i,
    input  logic          hi_i,
    input  logic [DW-1:0] rdata_i,
    output logic [DW-1:0] pins_o,
    output logic [1:0]    oe_o
);
    localparam int unsigned HW = DW / 2;

    logic [HW-1:0] lane;

    always_comb begin
        lane = hi_i ? rdata_i[DW-1:HW] : rdata_i[HW-1:0];
        if (byte_i) begin
            pins_o = {{HW{1'b0}}, (sep_i ? ~lane : lane)};
            oe_o   = 2'b01;
        end else begin
            pins_o = sep_i ? ~rdata_i : rdata_i;
            oe_o   = 2'b11;
        end
    end
endmodule

// File: rtl/hba_ctrl.sv
module hba_ctrl
    import hba_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic          write_i,
    input  logic [AW-1:0] addr_i,
    input  logic          hi_i,
    input  logic          byte_i,
    input  logic          sep_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [1:0]    be_i,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] rd_pins_i,
    input  logic [1:0]    rd_oe_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic [1:0]    mem_be_o,
    output logic          lat_hi_o,
    output logic          lat_byte_o,
    output logic          lat_sep_o,
    output logic          ack_n_o,
    output logic [DW-1:0] dout_o,
    output logic [1:0]    oe_o
);
    typedef struct packed {
        hba_state_e    st;
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [1:0]    be;
        logic          hi;
        logic          byte_m;
        logic          sep;
        logic          ack_n;
        logic [DW-1:0] dout;
        logic [1:0]    oe;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (active_i) begin
                    c_d.st     = ST_REQ;
                    c_d.req    = 1'b1;
                    c_d.we     = write_i;
                    c_d.addr   = addr_i;
                    c_d.wdata  = wdata_i;
                    c_d.be     = be_i;
                    c_d.hi     = hi_i;
                    c_d.byte_m = byte_i;
                    c_d.sep    = sep_i;
                end
            end
            ST_REQ: begin
                if (mem_ack_i) begin
                    c_d.st    = ST_DONE;
                    c_d.req   = 1'b0;
                    c_d.ack_n = 1'b0;
                    if (!c_q.we) begin
                        c_d.dout = rd_pins_i;
                        c_d.oe   = rd_oe_i;
                    end
                end
            end
            ST_DONE: begin
                if (!active_i) begin
                    c_d.st    = ST_IDLE;
                    c_d.ack_n = 1'b1;
                    c_d.oe    = 2'b00;
                    c_d.dout  = '0;
                end
            end
            default: begin
                c_d.st    = ST_IDLE;
                c_d.req   = 1'b0;
                c_d.ack_n = 1'b1;
                c_d.oe    = 2'b00;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, ack_n: 1'b1, be: 2'b00, oe: 2'b00,
                     default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign mem_req_o   = c_q.req;
    assign mem_we_o    = c_q.we;
    assign mem_addr_o  = c_q.addr;
    assign mem_wdata_o = c_q.wdata;
    assign mem_be_o    = c_q.be;
    assign lat_hi_o    = c_q.hi;
    assign lat_byte_o  = c_q.byte_m;
    assign lat_sep_o   = c_q.sep;
    assign ack_n_o     = c_q.ack_n;
    assign dout_o      = c_q.dout;
    assign oe_o        = c_q.oe;

    // R4
    ack_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n_o) |-> $past(mem_req_o && mem_ack_i));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n_o && !active_i) |=> (ack_n_o && oe_o == 2'b00));

    // R7
    byte_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && lat_byte_o) |-> ($countones(mem_be_o) == 1));

    // R8
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_byte_o && oe_o != 2'b00) |-> (oe_o == 2'b01));
endmodule

// File: rtl/hba_top.sv
module hba_top
    import hba_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_sep_strobe,
    input  logic          cfg_byte_mode,
    input  logic [AW-1:0] host_addr,
    input  logic          host_hi_sel,
    input  logic          host_strb_n,
    input  logic          host_dir,
    input  logic [DW-1:0] host_data_i,
    output logic [DW-1:0] host_data_o,
    output logic [1:0]    host_data_oe,
    output logic          host_ack_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [1:0]    mem_be,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    logic [1:0]    strb_s;
    logic          s_strb_n, s_dir;
    logic          act, wr;
    logic [DW-1:0] fmt_wdata;
    logic [1:0]    fmt_be;
    logic [DW-1:0] fmt_pins;
    logic [1:0]    fmt_oe;
    logic          lat_hi, lat_byte, lat_sep;
    logic          act_raw;

    hba_sync #(.W(2), .RESET_VAL(2'b11)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({host_strb_n, host_dir}),
        .q_o   (strb_s)
    );

    assign s_strb_n = strb_s[1];
    assign s_dir    = strb_s[0];

    always_comb begin
        act     = cfg_sep_strobe ? (!s_strb_n || !s_dir) : !s_strb_n;
        wr      = !s_dir;
        act_raw = cfg_sep_strobe ? (!host_strb_n || !host_dir) : !host_strb_n;
    end

    hba_wr_fmt #(.DW(DW)) i_wr_fmt (
        .sep_i   (cfg_sep_strobe),
        .byte_i  (cfg_byte_mode),
        .hi_i    (host_hi_sel),
        .pins_i  (host_data_i),
        .wdata_o (fmt_wdata),
        .be_o    (fmt_be)
    );

    hba_rd_fmt #(.DW(DW)) i_rd_fmt (
        .sep_i   (lat_sep),
        .byte_i  (lat_byte),
        .hi_i    (lat_hi),
        .rdata_i (mem_rdata),
        .pins_o  (fmt_pins),
        .oe_o    (fmt_oe)
    );

    hba_ctrl #(.AW(AW), .DW(DW)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (act),
        .write_i     (wr),
        .addr_i      (host_addr),
        .hi_i        (host_hi_sel),
        .byte_i      (cfg_byte_mode),
        .sep_i       (cfg_sep_strobe),
        .wdata_i     (fmt_wdata),
        .be_i        (fmt_be),
        .mem_ack_i   (mem_ack),
        .rd_pins_i   (fmt_pins),
        .rd_oe_i     (fmt_oe),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_be_o    (mem_be),
        .lat_hi_o    (lat_hi),
        .lat_byte_o  (lat_byte),
        .lat_sep_o   (lat_sep),
        .ack_n_o     (host_ack_n),
        .dout_o      (host_data_o),
        .oe_o        (host_data_oe)
    );

    // R4
    drive_when_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_oe != 2'b00) |-> !host_ack_n);

    // R10
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(act_raw, 2));
endmodule

// File: tb/test_hba_top.sv
module test_hba_top;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_sep_strobe = 1'b0;
    logic          cfg_byte_mode = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic          host_hi_sel = 1'b0;
    logic          host_strb_n = 1'b1;
    logic          host_dir = 1'b1;
    logic [DW-1:0] host_data_i = '0;
    logic [DW-1:0] host_data_o;
    logic [1:0]    host_data_oe;
    logic          host_ack_n;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [1:0]    mem_be;
    logic          mem_ack;
    logic [DW-1:0] mem_rdata;

    logic [DW-1:0] mem_model [256];
    logic [DW-1:0] exp_mem   [256];
    int lat = 0;
    int lat_cnt;
    int nvec = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    hba_top #(.AW(AW), .DW(DW)) i_hba_top (
        .clk(clk), .rst_n(rst_n),
        .cfg_sep_strobe(cfg_sep_strobe), .cfg_byte_mode(cfg_byte_mode),
        .host_addr(host_addr), .host_hi_sel(host_hi_sel),
        .host_strb_n(host_strb_n), .host_dir(host_dir),
        .host_data_i(host_data_i), .host_data_o(host_data_o),
        .host_data_oe(host_data_oe), .host_ack_n(host_ack_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            lat_cnt   <= 0;
            for (int i = 0; i < 256; i++) mem_model[i] <= 16'(i * 257) ^ 16'h5AA5;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (lat_cnt >= lat) begin
                    mem_ack   <= 1'b1;
                    lat_cnt   <= 0;
                    mem_rdata <= mem_model[mem_addr];
                    if (mem_we) begin
                        if (mem_be[0]) mem_model[mem_addr][7:0]  <= mem_wdata[7:0];
                        if (mem_be[1]) mem_model[mem_addr][15:8] <= mem_wdata[15:8];
                    end
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        nvec++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] a, input bit hi,
                          input logic [15:0] pin_d,
                          output logic [15:0] pins_o, output logic [1:0] oe_o);
        int n;
        @(negedge clk);
        host_addr   = a;
        host_hi_sel = hi;
        host_data_i = pin_d;
        if (!cfg_sep_strobe) begin
            host_dir    = !wr;
            host_strb_n = 1'b0;
        end else if (wr) begin
            host_dir = 1'b0;
        end else begin
            host_strb_n = 1'b0;
        end
        @(negedge clk);
        chk("R10 no request one edge after strobe", 32'(mem_req), 32'd0);
        n = 0;
        while (!mem_req && n < 20) begin @(negedge clk); n++; end
        chk("R5 request address", 32'(mem_addr), 32'(a));
        chk("R5 request direction", 32'(mem_we), 32'(wr));
        if (cfg_byte_mode)
            chk("R7 byte enable", 32'(mem_be), hi ? 32'd2 : 32'd1);
        else
            chk("R6 byte enable", 32'(mem_be), 32'd3);
        n = 0;
        while (host_ack_n && n < 60) begin @(negedge clk); n++; end
        chk("R4 acknowledge reached", 32'(host_ack_n), 32'd0);
        pins_o = host_data_o;
        oe_o   = host_data_oe;
        if (wr) chk("R4 no drive on write", 32'(host_data_oe), 32'd0);
        host_strb_n = 1'b1;
        if (cfg_sep_strobe) host_dir = 1'b1;
        n = 0;
        while ((host_ack_n == 1'b0 || host_data_oe != 2'b00) && n < 10) begin
            @(negedge clk); n++;
        end
        chk("R9 release within 3 cycles", 32'(n <= 3), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [15:0] pins, d, w, pin_d, exp_pins;
        logic [7:0]  v, a;
        logic [1:0]  oe;
        string       tg;
        for (int i = 0; i < 256; i++) exp_mem[i] = 16'(i * 257) ^ 16'h5AA5;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 ack idle in reset", 32'(host_ack_n), 32'd1);
        chk("R1 bus released in reset", 32'(host_data_oe), 32'd0);
        chk("R1 no request in reset", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 ack idle after reset", 32'(host_ack_n), 32'd1);
        chk("R1 bus released after reset", 32'(host_data_oe), 32'd0);
        chk("R1 no request after reset", 32'(mem_req), 32'd0);

        for (int sp = 0; sp < 2; sp++) begin
            for (int bm = 0; bm < 2; bm++) begin
                @(negedge clk);
                cfg_sep_strobe = sp[0];
                cfg_byte_mode  = bm[0];
                host_strb_n    = 1'b1;
                host_dir       = 1'b1;
                for (int ai = 0; ai < 8; ai++) begin
                    for (int hi = 0; hi < 2; hi++) begin
                        for (int p = 0; p < 3; p++) begin
                            a   = 8'((ai * 37) % 256);
                            d   = 16'(ai * 16'h0123 + p * 16'h3C5A + hi * 16'h8001
                                      + sp * 7 + bm * 11 + 16'h1200);
                            lat = (ai + p + hi) % 4;
                            tg  = bm != 0 ? "R7" : (hi != 0 ? "R6" : (sp != 0 ? "R3" : "R2"));
                            pin_d = sp != 0 ? ~d : d;
                            access(1'b1, a, hi[0], pin_d, pins, oe);
                            @(negedge clk);
                            if (bm != 0) begin
                                if (hi != 0) exp_mem[a][15:8] = d[7:0];
                                else         exp_mem[a][7:0]  = d[7:0];
                            end else begin
                                exp_mem[a] = d;
                            end
                            chk({tg, " stored word"}, 32'(mem_model[a]), 32'(exp_mem[a]));

                            tg = bm != 0 ? "R8" : (hi != 0 ? "R6" : (sp != 0 ? "R3" : "R2"));
                            access(1'b0, a, hi[0], 16'hFFFF, pins, oe);
                            w = exp_mem[a];
                            if (bm != 0) begin
                                v = hi != 0 ? w[15:8] : w[7:0];
                                exp_pins = {8'h00, (sp != 0 ? ~v : v)};
                                chk({tg, " lane enable"}, 32'(oe), 32'd1);
                            end else begin
                                exp_pins = sp != 0 ? ~w : w;
                                chk({tg, " lane enable"}, 32'(oe), 32'd3);
                            end
                            chk({tg, " read pins"}, 32'(pins), 32'(exp_pins));
                        end
                    end
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule